// File: doc/BRIEF.md
# Timer Control Word and Byte-Access Port

This block is the processor-side register port of a three-channel interval timer. The port has a 2-bit address, an 8-bit write bus and an 8-bit read bus. Address 3 takes control words. Addresses 0 to 2 reach the count of channels 0 to 2. The block does no counting. It decodes the control words and keeps the per-channel configuration, meaning the access mode, the operating mode and the BCD flag. It also holds a status byte and a latched count for each channel. It assembles byte writes into 16-bit load values, and it steps through low and high bytes on reads.

Each counter channel receives a one-cycle load strobe together with the assembled 16-bit value. Each channel also receives its operating mode and BCD flag. In return, each channel supplies its live count and its OUT level. A read is combinational: `rdata_o` is valid in the same cycle as `rd_i`, and the read's side effects take hold at the clock edge that ends that cycle. Writes act at the clock edge. A load strobe appears in the cycle after the write that completes it. A read asserted in the same cycle as a write is ignored.

Top module: `timer_ctrl_port`

## Requirements
- R1: After reset, every channel has access mode 3 (low byte then high byte), operating mode 0 and BCD 0. No latch is pending, both byte toggles point at the low byte, and `load_o` is all zero.
- R2: A write to address 3 is decoded as follows: bits 7:6 select the channel, bits 5:4 give the access mode, bits 3:1 give the operating mode and bit 0 gives BCD. With an access mode of 1, 2 or 3, the selected channel takes the new settings, and `mode_o`/`bcd_o` show them in the next cycle. Operating modes 6 and 7 are stored as 2 and 3. A control write never produces a load strobe.
- R3: A control word with access mode 0 is a counter latch command. It captures the channel's live count and leaves that channel's settings unchanged. The command is ignored while an unread latched count is pending on that channel.
- R4: A control word with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches the count and bit 4 = 0 latches the status. Each kind of latch is ignored on a channel that already holds an unread latch of that kind.
- R5: A latched status byte holds the channel's OUT level at the moment of latching in bit 7, zero in bit 6, the access mode in bits 5:4, the operating mode in bits 3:1 and BCD in bit 0.
- R6: A read of a channel returns a pending status byte first. With no status pending, it returns a pending latched count. Only when neither is pending does it return the live count. Each read consumes the item it returned.
- R7: In access mode 1, a data write loads the value {8'h00, byte}. In access mode 2, it loads {byte, 8'h00}. The load appears as a one-cycle strobe on that channel's bit of `load_o` in the next cycle, with the value on `load_val_o`.
- R8: In access mode 3, the first data write is held as the low byte and produces no strobe. The second data write loads {byte, held low byte}.
- R9: In access mode 3, reads alternate between the low byte and the high byte. A latched count taken in mode 3 reads low then high and is then released. A latched count taken in mode 1 or mode 2 is released after one read of its low byte or high byte respectively.
- R10: Programming a channel with a new control word resets its write toggle and its read toggle to the low byte.
- R11: A read at address 3 returns 8'h00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 to 2 select a channel, 3 selects the control word |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational for the addressed channel |
| live_cnt_i | input | 48 | Live count of each channel, channel c in bits 16c+15:16c |
| chan_out_i | input | 3 | OUT level of each channel |
| load_o | output | 3 | One-cycle load strobe for each channel |
| load_val_o | output | 16 | Assembled 16-bit load value |
| mode_o | output | 9 | Operating mode of each channel, 3 bits each |
| bcd_o | output | 3 | BCD flag of each channel |

## Verification
Several kinds of wrong internal state show up on the ports. A wrong write toggle shows as a strobe that is missing, early or byte-swapped, in the cycle after the second data write. A wrong read toggle or a latch that never releases shows as wrong bytes on the next read of that channel. A wrong latch priority shows on the first read after a read-back command. Latched values and live values are easy to tell apart because the live counts change on every cycle. The bench compares the strobes, the value, the modes and the read data with a behavioural model on every clock. Any divergence is therefore reported within one cycle of the access that exposes it.

// File: rtl/tmr_port_pkg.sv
package tmr_port_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_word_t;

  // modes 6 and 7 alias 2 and 3
  function automatic logic [2:0] fold_mode(logic [2:0] m);
    return (m > 3'd5) ? (m - 3'd4) : m;
  endfunction
endpackage

// File: rtl/tp_cmd_decode.sv
module tp_cmd_decode
  import tmr_port_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NCH-1:0] prog_o,
  output logic [NCH-1:0] cnt_latch_o,
  output logic [NCH-1:0] sts_latch_o,
  output logic [NCH-1:0] data_wr_o,
  output acc_e          acc_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);
  ctl_word_t ctl;
  logic      is_ctl, is_rb;

  always_comb begin
    ctl    = ctl_word_t'(wdata_i);
    is_ctl = wr_i && (addr_i == 2'd3);
    is_rb  = (ctl.sel == 2'd3);
    acc_o  = ctl.acc;
    mode_o = fold_mode(ctl.mode);
    bcd_o  = ctl.bcd;
    for (int c = 0; c < NCH; c++) begin
      prog_o[c]      = is_ctl && !is_rb && (ctl.sel == 2'(c)) && (ctl.acc != ACC_LATCH);
      cnt_latch_o[c] = is_ctl && (is_rb ? (wdata_i[c+1] && !wdata_i[5])
                                        : ((ctl.sel == 2'(c)) && (ctl.acc == ACC_LATCH)));
      sts_latch_o[c] = is_ctl && is_rb && wdata_i[c+1] && !wdata_i[4];
      data_wr_o[c]   = wr_i && (addr_i == 2'(c));
    end
  end
endmodule

// File: rtl/tp_chan.sv
module tp_chan
  import tmr_port_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  acc_e          acc_i,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic          cnt_latch_i,
  input  logic          sts_latch_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] live_i,
  input  logic          out_i,
  output logic [DW-1:0] rdata_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);
  acc_e          acc_q, cl_q;
  logic [2:0]    mode_q;
  logic          bcd_q, wr_hi_q, rd_hi_q, sts_vld_q;
  logic [DW-1:0] wr_lo_q, sts_q;
  logic [CW-1:0] cl_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= ACC_WORD;
      mode_q    <= 3'd0;
      bcd_q     <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      wr_lo_q   <= '0;
      sts_vld_q <= 1'b0;
      sts_q     <= '0;
      cl_q      <= ACC_LATCH;   // ACC_LATCH here means no latch pending
      cl_val_q  <= '0;
    end else begin
      if (prog_i) begin
        acc_q   <= acc_i;
        mode_q  <= mode_i;
        bcd_q   <= bcd_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (cnt_latch_i && (cl_q == ACC_LATCH)) begin
        cl_q     <= acc_q;
        cl_val_q <= live_i;
      end
      if (sts_latch_i && !sts_vld_q) begin
        sts_vld_q <= 1'b1;
        sts_q     <= {out_i, 1'b0, acc_q, mode_q, bcd_q};
      end
      if (wr_i && (acc_q == ACC_WORD)) begin
        if (!wr_hi_q) begin
          wr_lo_q <= wdata_i;
          wr_hi_q <= 1'b1;
        end else begin
          wr_hi_q <= 1'b0;
        end
      end
      if (rd_i) begin
        if (sts_vld_q) sts_vld_q <= 1'b0;
        else if (cl_q != ACC_LATCH) cl_q <= (cl_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
        else if (acc_q == ACC_WORD) rd_hi_q <= !rd_hi_q;
      end
    end
  end

  always_comb begin
    load_o = wr_i && ((acc_q != ACC_WORD) || wr_hi_q);
    unique case (acc_q)
      ACC_HI:   load_val_o = {wdata_i, {DW{1'b0}}};
      ACC_WORD: load_val_o = {wdata_i, wr_lo_q};
      default:  load_val_o = {{DW{1'b0}}, wdata_i};
    endcase
    if (sts_vld_q)
      rdata_o = sts_q;
    else if (cl_q != ACC_LATCH)
      rdata_o = (cl_q == ACC_HI) ? cl_val_q[CW-1:DW] : cl_val_q[DW-1:0];
    else if ((acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi_q))
      rdata_o = live_i[CW-1:DW];
    else
      rdata_o = live_i[DW-1:0];
  end

  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;
endmodule

// File: rtl/timer_ctrl_port.sv
module timer_ctrl_port
  import tmr_port_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NCH*CW-1:0] live_cnt_i,
  input  logic [NCH-1:0]   chan_out_i,
  output logic [NCH-1:0]   load_o,
  output logic [CW-1:0]    load_val_o,
  output logic [NCH*3-1:0] mode_o,
  output logic [NCH-1:0]   bcd_o
);
  logic [NCH-1:0] prog, cnt_latch, sts_latch, data_wr, ch_rd, ch_load;
  acc_e           dec_acc;
  logic [2:0]     dec_mode;
  logic           dec_bcd;
  logic [DW-1:0]  ch_rdata [NCH];
  logic [CW-1:0]  ch_lval  [NCH];
  logic [CW-1:0]  lval_mux;

  tp_cmd_decode #(.NCH(NCH)) u_dec (
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .prog_o      (prog),
    .cnt_latch_o (cnt_latch),
    .sts_latch_o (sts_latch),
    .data_wr_o   (data_wr),
    .acc_o       (dec_acc),
    .mode_o      (dec_mode),
    .bcd_o       (dec_bcd)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_rd[c] = rd_i && !wr_i && (addr_i == 2'(c));
    tp_chan u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .prog_i      (prog[c]),
      .acc_i       (dec_acc),
      .mode_i      (dec_mode),
      .bcd_i       (dec_bcd),
      .cnt_latch_i (cnt_latch[c]),
      .sts_latch_i (sts_latch[c]),
      .wr_i        (data_wr[c]),
      .rd_i        (ch_rd[c]),
      .wdata_i     (wdata_i),
      .live_i      (live_cnt_i[c*CW +: CW]),
      .out_i       (chan_out_i[c]),
      .rdata_o     (ch_rdata[c]),
      .load_o      (ch_load[c]),
      .load_val_o  (ch_lval[c]),
      .mode_o      (mode_o[c*3 +: 3]),
      .bcd_o       (bcd_o[c])
    );
  end

  always_comb begin
    rdata_o  = '0;
    lval_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == 2'(c)) rdata_o = ch_rdata[c];
      if (ch_load[c]) lval_mux = lval_mux | ch_lval[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o     <= '0;
      load_val_o <= '0;
    end else begin
      load_o     <= ch_load;
      load_val_o <= lval_mux;
    end
  end
endmodule

// File: rtl/tp_port_chk.sv
module tp_port_chk #(
  parameter int NCH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       addr_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [7:0]       rdata_o,
  input logic [NCH-1:0]   load_o,
  input logic [NCH*3-1:0] mode_o
);
  a_r7_load_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o));

  a_r7_load_after_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o != '0) |-> $past(wr_i && (addr_i != 2'd3)));

  a_r2_ctrl_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == 2'd3)) |=> (load_o == '0));

  a_r2_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == 2'd3)) |=> $stable(mode_o));

  a_r11_addr3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == 2'd3)) |-> (rdata_o == 8'h00));
endmodule

bind timer_ctrl_port tp_port_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/timer_ctrl_port_test.sv
module timer_ctrl_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] live;
  logic [2:0]  chout = '0;
  logic [2:0]  load;
  logic [15:0] load_val;
  logic [8:0]  mode;
  logic [2:0]  bcd;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_acc[3], m_mode[3], m_bcd[3], m_wrhi[3], m_wrlo[3], m_rdhi[3];
  int m_sv[3], m_st[3], m_cl[3], m_clv[3];
  int e_load, e_lval;
  int lv[3];

  timer_ctrl_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .live_cnt_i(live), .chan_out_i(chout),
    .load_o(load), .load_val_o(load_val), .mode_o(mode), .bcd_o(bcd)
  );

  always #10 clk = ~clk;

  assign live = {lv[2][15:0], lv[1][15:0], lv[0][15:0]};

  task automatic cmp(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic int model_rd(int a);
    if (a == 3) return 0;
    if (m_sv[a] != 0) return m_st[a];
    if (m_cl[a] != 0) return (m_cl[a] == 2) ? (m_clv[a] >> 8) & 255 : m_clv[a] & 255;
    if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rdhi[a] != 0)) return (lv[a] >> 8) & 255;
    return lv[a] & 255;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_wrhi[c] = 0; m_wrlo[c] = 0;
      m_rdhi[c] = 0; m_sv[c] = 0; m_st[c] = 0; m_cl[c] = 0; m_clv[c] = 0;
    end
    e_load = 0; e_lval = 0;
  endtask

  task automatic latch_cnt(int c);
    if (m_cl[c] == 0) begin m_cl[c] = m_acc[c]; m_clv[c] = lv[c]; end
  endtask

  task automatic model_edge(bit w, bit r, int a, int d);
    int sel, ac, md;
    e_load = 0;
    if (w && a == 3) begin
      sel = d >> 6; ac = (d >> 4) & 3; md = (d >> 1) & 7;
      if (md > 5) md -= 4;
      if (sel == 3) begin
        for (int c = 0; c < 3; c++) if (d[c+1]) begin
          if (!d[5]) latch_cnt(c);
          if (!d[4] && m_sv[c] == 0) begin
            m_sv[c] = 1;
            m_st[c] = (int'(chout[c]) << 7) | (m_acc[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
          end
        end
      end else if (ac == 0) latch_cnt(sel);
      else begin
        m_acc[sel] = ac; m_mode[sel] = md; m_bcd[sel] = d & 1;
        m_wrhi[sel] = 0; m_rdhi[sel] = 0;
      end
    end else if (w) begin
      if (m_acc[a] == 1) begin e_load = 1 << a; e_lval = d; end
      else if (m_acc[a] == 2) begin e_load = 1 << a; e_lval = d << 8; end
      else if (m_wrhi[a] == 0) begin m_wrlo[a] = d; m_wrhi[a] = 1; end
      else begin e_load = 1 << a; e_lval = m_wrlo[a] | (d << 8); m_wrhi[a] = 0; end
    end else if (r && a != 3) begin
      if (m_sv[a] != 0) m_sv[a] = 0;
      else if (m_cl[a] != 0) m_cl[a] = (m_cl[a] == 3) ? 2 : 0;
      else if (m_acc[a] == 3) m_rdhi[a] = 1 - m_rdhi[a];
    end
  endtask

  // one cycle: entered and left at a falling edge
  task automatic step(bit w, bit r, int a, int d);
    wr = w; rd = r; addr = 2'(a); wdata = 8'(d);
    for (int c = 0; c < 3; c++) lv[c] = (16'hA000 + c * 16'h1357 - cyc * 7) & 16'hFFFF;
    chout = 3'(cyc / 3);
    #1;
    if (r && !w) cmp(cur_req, int'(rdata), model_rd(a));
    @(posedge clk);
    model_edge(w, r, a, d);
    cyc++;
    @(negedge clk);
    cmp(cur_req, int'(load), e_load);
    if (e_load != 0) cmp(cur_req, int'(load_val), e_lval);
    for (int c = 0; c < 3; c++) begin
      cmp(cur_req, int'(mode[c*3 +: 3]), m_mode[c]);
      cmp(cur_req, int'(bcd[c]), m_bcd[c]);
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0); endtask
  task automatic wrb(int a, int d); step(1, 0, a, d); endtask
  task automatic rdb(int a); step(0, 1, a, 0); endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    for (int c = 0; c < 3; c++) lv[c] = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(); rdb(1); rdb(1); rdb(1);
    wrb(3, 8'hC2); rdb(0);                   // R1/R5: status of reset state
    cur_req = "R2"; wrb(3, 8'h15); wrb(3, 8'h7E); wrb(3, 8'hAC); idle();
    cur_req = "R7"; wrb(0, 8'h5A); idle(); wrb(2, 8'h3C); wrb(0, 8'h01);
    rdb(0); rdb(2);
    cur_req = "R8"; wrb(1, 8'h34); idle(); wrb(1, 8'h12); idle();
    cur_req = "R10"; wrb(1, 8'h77); rdb(1); wrb(3, 8'h76); wrb(1, 8'h11); wrb(1, 8'h22);
    rdb(1); rdb(1); rdb(1);
    cur_req = "R3"; wrb(3, 8'h40); idle(); idle(); wrb(3, 8'h40); idle();
    rdb(1); idle(); rdb(1); rdb(1);
    cur_req = "R9"; wrb(3, 8'h00); rdb(0); rdb(0); wrb(3, 8'h80); rdb(2); rdb(2);
    cur_req = "R4"; wrb(3, 8'hCE); idle(); rdb(0); rdb(0); rdb(0);
    rdb(1); rdb(1); rdb(1); rdb(1); rdb(2); rdb(2); rdb(2);
    cur_req = "R5"; wrb(3, 8'hE8); idle(); wrb(3, 8'hE8); rdb(2); rdb(2);
    wrb(3, 8'hD4); rdb(1); rdb(1); rdb(1);
    cur_req = "R6"; wrb(3, 8'hC2); wrb(3, 8'hC2); rdb(0); rdb(0); rdb(0);
    cur_req = "R11"; rdb(3); rdb(1); rdb(3); rdb(1); wrb(1, 8'h9A); rdb(3); wrb(1, 8'hBC);
    idle(); idle();
    report();
  end
endmodule